// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a load/store port and a memory master. It keeps recently used data in a direct-mapped array of 32-byte lines, so each line holds eight 32-bit words. The number of lines is a parameter. On a hit, a load returns its word in the same cycle as the request. A store hit is also accepted in the same cycle and changes only the cached copy, which then becomes dirty.

On a miss the cache stalls the request. If the line it must replace is dirty, it first writes that line back to memory in full, one word per clock, in ascending order. It then refills the line, issuing eight reads on consecutive clocks, starting at word 0. When the last read data has arrived, the line becomes valid and clean. The held request then completes as a hit. For a store miss this means the line is allocated first and the store bytes are merged afterwards.

The memory side has separate read and write channels. The memory must accept one beat per clock and must return read data in order, at any fixed or varying latency.

Top module: `wb_dcache`

## Requirements
- R1: After reset every line is invalid and clean. With no request pending, stall, read issue and write valid are all low. The first access to any address misses and causes no write-back.
- R2: A load that hits raises ack in the cycle the request is presented, with stall low and no memory traffic. It returns the stored word.
- R3: A miss whose victim is invalid or clean issues exactly eight reads and no writes. The read byte addresses are the line base plus 4*k for k = 0..7, in that order, on consecutive clocks. The load then returns the word memory held.
- R4: A store that hits is acked in the same cycle and causes no memory traffic. Byte enable bit i selects data bits 8*i+7..8*i, and unselected bytes keep their old value.
- R5: A store that misses first refills the line (no write-through), then merges its bytes under the byte enables. The other words of the line equal memory.
- R6: A miss on a valid dirty line writes all eight victim words before any read. The write addresses are the victim base plus 4*k for k = 0..7, ascending, on consecutive clocks, and they carry the latest stored data.
- R7: A refill leaves the line clean, so evicting a line that has not been stored to since its refill causes no write.
- R8: While a request waits, stall is high every cycle and ack is low. Ack and stall are never high together. The requester holds the request stable while stall is high.
- R9: The tag covers every byte address bit above the index, up to bit 30 (a 31-bit byte address). Two addresses that differ only in bit 30 are different lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_waddr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1..2) |
| cpu_be | input | 4 | Store byte enables, bit i for byte lane i |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with ack |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request is waiting on write-back or refill |
| mem_rd_req | output | 1 | Read beat issued this cycle |
| mem_rd_addr | output | ADDR_W | Byte address of the read beat |
| mem_rsp_valid | input | 1 | Read data beat returned, in issue order |
| mem_rsp_data | input | 32 | Returned read data |
| mem_wr_valid | output | 1 | Write beat issued this cycle |
| mem_wr_addr | output | ADDR_W | Byte address of the write beat |
| mem_wr_data | output | 32 | Write data |

## Verification
A wrong valid or tag bit shows up at the ports in the cycle of the next access to that index. A false hit acks at once with stale data, and a false miss raises stall and read traffic that should not be there. A lost or spurious dirty bit shows up only when the line is evicted, as missing or extra write beats. The bench therefore evicts every line it has stored to and compares the written words with its own shadow memory. A wrong beat counter shows up within one burst as a non-ascending address, a gap between beats, or a beat count other than eight.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;
   localparam int OFS_W      = 5;            // 32-byte line
   localparam int WORD_W     = 32;
   localparam int BE_W       = WORD_W / 8;
   localparam int LINE_WORDS = 8;
   localparam int WSEL_W     = $clog2(LINE_WORDS);
   localparam int CNT_W      = WSEL_W + 1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_FILL = 2'd2
   } dc_state_e;
endpackage

// File: rtl/wb_dcache_tags.sv
module wb_dcache_tags #(
   parameter int LINES = 16,
   parameter int TAG_W = 22,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             dirty_set,
   output logic             line_valid,
   output logic             line_dirty,
   output logic [TAG_W-1:0] line_tag
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (dirty_set) begin
         dirty_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[idx] <= fill_tag;
   end

   assign line_valid = valid_q[idx];
   assign line_dirty = dirty_q[idx];
   assign line_tag   = tag_q[idx];

   AST_DIRTY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_set |-> valid_q[idx]) else $error("store marked an invalid line"); // R4
   AST_FILL_NOT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> !dirty_set) else $error("fill and store in one cycle"); // R5
   AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> line_valid && !line_dirty) else $error("refilled line not clean"); // R7
endmodule

// File: rtl/wb_dcache_data.sv
module wb_dcache_data
   import wb_dcache_pkg::*;
#(
   parameter int LINES = 16,
   localparam int IDX_W = $clog2(LINES),
   localparam int AW    = IDX_W + WSEL_W,
   localparam int DEPTH = LINES * LINE_WORDS
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rda_addr,
   output logic [WORD_W-1:0] rda_data,
   input  logic [AW-1:0]     rdb_addr,
   output logic [WORD_W-1:0] rdb_data
);
   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      logic [7:0] lane_q [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_be[b]) lane_q[wr_addr] <= wr_data[8*b +: 8];
      end

      assign rda_data[8*b +: 8] = lane_q[rda_addr];
      assign rdb_data[8*b +: 8] = lane_q[rdb_addr];
   end
endmodule

// File: rtl/wb_dcache_ctrl.sv
module wb_dcache_ctrl
   import wb_dcache_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              hit,
   input  logic              victim_dirty,
   input  logic              mem_rsp_valid,
   output logic              wb_active,
   output logic              rd_issue,
   output logic              fill_wr,
   output logic              fill_last,
   output logic              cpu_ack,
   output logic              cpu_stall,
   output logic [WSEL_W-1:0] beat,
   output logic [WSEL_W-1:0] rsp_word
);
   dc_state_e        state_q;
   logic [CNT_W-1:0] beat_q;
   logic [WSEL_W-1:0] rsp_q;

   localparam logic [CNT_W-1:0]  LAST_BEAT = CNT_W'(LINE_WORDS - 1);
   localparam logic [CNT_W-1:0]  ALL_BEATS = CNT_W'(LINE_WORDS);
   localparam logic [WSEL_W-1:0] LAST_RSP  = WSEL_W'(LINE_WORDS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         rsp_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cpu_req && !hit) begin
                  beat_q  <= '0;
                  rsp_q   <= '0;
                  state_q <= victim_dirty ? ST_WB : ST_FILL;
               end
            end
            ST_WB: begin
               if (beat_q == LAST_BEAT) begin
                  beat_q  <= '0;
                  state_q <= ST_FILL;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            ST_FILL: begin
               if (rd_issue) beat_q <= beat_q + 1'b1;
               if (mem_rsp_valid) begin
                  rsp_q <= rsp_q + 1'b1;
                  if (rsp_q == LAST_RSP) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign wb_active = (state_q == ST_WB);
   assign rd_issue  = (state_q == ST_FILL) && (beat_q < ALL_BEATS);
   assign fill_wr   = (state_q == ST_FILL) && mem_rsp_valid;
   assign fill_last = fill_wr && (rsp_q == LAST_RSP);
   assign cpu_ack   = (state_q == ST_IDLE) && cpu_req && hit;
   assign cpu_stall = (state_q != ST_IDLE) || (cpu_req && !hit);
   assign beat      = beat_q[WSEL_W-1:0];
   assign rsp_word  = rsp_q;

   AST_ACK_NOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> !cpu_stall) else $error("ack with stall"); // R8
   AST_RSP_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> state_q == ST_FILL) else $error("read data outside refill"); // R3
   AST_RSP_BEHIND_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL) |-> ({1'b0, rsp_q} <= beat_q)) else $error("more data than reads"); // R3
   AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wb_active) |-> state_q == ST_FILL) else $error("write-back not followed by refill"); // R6
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
   import wb_dcache_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int ADDR_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-3:0] cpu_waddr,
   input  logic [BE_W-1:0]   cpu_be,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_ack,
   output logic              cpu_stall,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_data,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [WORD_W-1:0] mem_wr_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - OFS_W - IDX_W;
   localparam int DA_W  = IDX_W + WSEL_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the line count");
   end

   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [WSEL_W-1:0] req_word;
   assign req_tag  = cpu_waddr[ADDR_W-3 -: TAG_W];
   assign req_idx  = cpu_waddr[WSEL_W +: IDX_W];
   assign req_word = cpu_waddr[WSEL_W-1:0];

   logic              line_valid, line_dirty;
   logic [TAG_W-1:0]  line_tag;
   logic              hit, victim_dirty;
   logic              wb_active, rd_issue, fill_wr, fill_last;
   logic [WSEL_W-1:0] beat, rsp_word;

   assign hit          = line_valid && (line_tag == req_tag);
   assign victim_dirty = line_valid && line_dirty;

   wb_dcache_ctrl i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_req      (cpu_req),
      .hit          (hit),
      .victim_dirty (victim_dirty),
      .mem_rsp_valid(mem_rsp_valid),
      .wb_active    (wb_active),
      .rd_issue     (rd_issue),
      .fill_wr      (fill_wr),
      .fill_last    (fill_last),
      .cpu_ack      (cpu_ack),
      .cpu_stall    (cpu_stall),
      .beat         (beat),
      .rsp_word     (rsp_word)
   );

   wb_dcache_tags #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (req_idx),
      .fill_en   (fill_last),
      .fill_tag  (req_tag),
      .dirty_set (cpu_ack && cpu_we),
      .line_valid(line_valid),
      .line_dirty(line_dirty),
      .line_tag  (line_tag)
   );

   logic              dwr_en;
   logic [DA_W-1:0]   dwr_addr;
   logic [BE_W-1:0]   dwr_be;
   logic [WORD_W-1:0] dwr_data;

   always_comb begin
      if (fill_wr) begin
         dwr_en   = 1'b1;
         dwr_addr = {req_idx, rsp_word};
         dwr_be   = '1;
         dwr_data = mem_rsp_data;
      end else begin
         dwr_en   = cpu_ack && cpu_we;
         dwr_addr = {req_idx, req_word};
         dwr_be   = cpu_be;
         dwr_data = cpu_wdata;
      end
   end

   wb_dcache_data #(.LINES(LINES)) i_data (
      .clk     (clk),
      .wr_en   (dwr_en),
      .wr_addr (dwr_addr),
      .wr_be   (dwr_be),
      .wr_data (dwr_data),
      .rda_addr({req_idx, req_word}),
      .rda_data(cpu_rdata),
      .rdb_addr({req_idx, beat}),
      .rdb_data(mem_wr_data)
   );

   assign mem_wr_valid = wb_active;
   assign mem_wr_addr  = {line_tag, req_idx, beat, 2'b00};
   assign mem_rd_req   = rd_issue;
   assign mem_rd_addr  = {req_tag, req_idx, beat, 2'b00};

   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_stall |=> cpu_req && $stable(cpu_waddr) && $stable(cpu_we))
      else $error("request changed while stalled"); // R8
   AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && $past(mem_rd_req) |-> mem_rd_addr == ADDR_W'($past(mem_rd_addr) + ADDR_W'(4)))
      else $error("read beats not ascending"); // R3
   AST_RD_FROM_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_req) |-> mem_rd_addr[OFS_W-1:0] == '0)
      else $error("refill not started at word 0"); // R3
   AST_WB_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && $past(mem_wr_valid) |-> mem_wr_addr == ADDR_W'($past(mem_wr_addr) + ADDR_W'(4)))
      else $error("write-back beats not ascending"); // R6
   AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> !mem_wr_valid && !mem_rd_req)
      else $error("memory traffic on a hit"); // R2
endmodule

// File: tb/test_wb_dcache.sv
`timescale 1ns/1ps
module test_wb_dcache;
   localparam int LINES  = 16;
   localparam int ADDR_W = 31;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0;
   logic              cpu_we = 1'b0;
   logic [ADDR_W-3:0] cpu_waddr = '0;
   logic [3:0]        cpu_be = '0;
   logic [31:0]       cpu_wdata = '0;
   logic [31:0]       cpu_rdata;
   logic              cpu_ack, cpu_stall;
   logic              mem_rd_req, mem_rsp_valid, mem_wr_valid;
   logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
   logic [31:0]       mem_rsp_data, mem_wr_data;

   always #2 clk = ~clk;   // 250 MHz

   wb_dcache #(.LINES(LINES), .ADDR_W(ADDR_W)) i_wb_dcache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
      .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data)
   );

   int total = 0;
   int bad   = 0;

   // ---------------- memory model and traffic log ----------------
   logic [31:0] mem  [2048];
   logic [31:0] shad [2048];
   int cyc = 0;
   int wr_n = 0, rd_n = 0;
   logic [ADDR_W-1:0] wr_a [16];
   logic [31:0]       wr_d [16];
   int                wr_c [16];
   logic [ADDR_W-1:0] rd_a [16];
   int                rd_c [16];
   logic        pv [2];
   logic [31:0] pd [2];

   function automatic int midx(input logic [ADDR_W-1:0] a);
      return int'({a[30], a[11:2]});
   endfunction

   function automatic logic [31:0] seed_word(input int i);
      return 32'h3C00_0000 ^ (32'(i) * 32'h0001_0207);
   endfunction

   function automatic logic [31:0] lane_mix(input logic [31:0] o, input logic [31:0] n,
                                            input logic [3:0] be);
      logic [31:0] r = o;
      for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
      return r;
   endfunction

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (mem_wr_valid) begin
         if (wr_n < 16) begin wr_a[wr_n] = mem_wr_addr; wr_d[wr_n] = mem_wr_data; wr_c[wr_n] = cyc; end
         mem[midx(mem_wr_addr)] = mem_wr_data;
         wr_n = wr_n + 1;
      end
      if (mem_rd_req) begin
         if (rd_n < 16) begin rd_a[rd_n] = mem_rd_addr; rd_c[rd_n] = cyc; end
         rd_n = rd_n + 1;
      end
      if (!rst_n) begin
         pv[0] <= 1'b0; pv[1] <= 1'b0;
      end else begin
         pv[0] <= mem_rd_req;
         pd[0] <= mem[midx(mem_rd_addr)];
         pv[1] <= pv[0];
         pd[1] <= pd[0];
      end
   end
   assign mem_rsp_valid = pv[1];
   assign mem_rsp_data  = pd[1];

   // ---------------- checking helpers ----------------
   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic access(input string req, input logic we, input logic [ADDR_W-1:0] a,
                         input logic [3:0] be, input logic [31:0] wd,
                         output logic [31:0] rd, output int waits);
      @(negedge clk);
      wr_n = 0; rd_n = 0;
      cpu_req = 1'b1; cpu_we = we; cpu_waddr = a[ADDR_W-1:2];
      cpu_be = be; cpu_wdata = wd;
      waits = 0;
      #1;
      while (!cpu_ack && waits < 100) begin
         if (!cpu_stall) begin
            total++; bad++;
            $display("FAIL R8 stall low while waiting: actual=0 expected=1");
         end
         @(negedge clk); #1;
         waits++;
      end
      if (cpu_stall) begin
         total++; bad++;
         $display("FAIL R8 stall with ack: actual=1 expected=0");
      end
      rd = cpu_rdata;
      if (we) shad[midx(a)] = lane_mix(shad[midx(a)], wd, be);
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic check_reads(input string req, input logic [ADDR_W-1:0] base);
      chk(req, "read beat count", 32'(rd_n), 32'd8);
      for (int k = 1; k < 8 && k < rd_n; k++) begin
         chk(req, "read addr", 32'(rd_a[k]), 32'(base) + 32'(4*k));
         chk(req, "read spacing", 32'(rd_c[k] - rd_c[k-1]), 32'd1);
      end
      if (rd_n > 0) chk(req, "first read addr", 32'(rd_a[0]), 32'(base));
   endtask

   task automatic check_writes(input string req, input logic [ADDR_W-1:0] base);
      chk(req, "write beat count", 32'(wr_n), 32'd8);
      for (int k = 0; k < 8 && k < wr_n; k++) begin
         chk(req, "write addr", 32'(wr_a[k]), 32'(base) + 32'(4*k));
         chk(req, "write data", wr_d[k], shad[midx(base) + k]);
         if (k > 0) chk(req, "write spacing", 32'(wr_c[k] - wr_c[k-1]), 32'd1);
      end
      if (wr_n > 0 && rd_n > 0)
         chk(req, "writes before reads", 32'(wr_c[wr_n-1] < rd_c[0]), 32'd1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [31:0] d; int w;
      @(negedge clk); #1;
      chk("R1", "idle stall", 32'(cpu_stall), 32'd0);
      chk("R1", "idle read issue", 32'(mem_rd_req), 32'd0);
      chk("R1", "idle write valid", 32'(mem_wr_valid), 32'd0);
      access("R1", 1'b0, 31'h000, 4'h0, 32'h0, d, w);
      chk("R1", "first access misses", 32'(w > 0), 32'd1);
      chk("R1", "no write-back after reset", 32'(wr_n), 32'd0);
      check_reads("R3", 31'h000);
      chk("R3", "load miss data", d, shad[midx(31'h000)]);
   endtask

   task automatic t_load_hit();
      logic [31:0] d; int w;
      access("R2", 1'b0, 31'h004, 4'h0, 32'h0, d, w);
      chk("R2", "hit waits", 32'(w), 32'd0);
      chk("R2", "hit data", d, shad[midx(31'h004)]);
      chk("R2", "hit traffic", 32'(wr_n + rd_n), 32'd0);
      access("R2", 1'b0, 31'h01C, 4'h0, 32'h0, d, w);
      chk("R2", "hit last word", d, shad[midx(31'h01C)]);
   endtask

   task automatic t_store_hit();
      logic [31:0] d; int w;
      access("R4", 1'b1, 31'h008, 4'b0101, 32'hDEAD_BEEF, d, w);
      chk("R4", "store hit waits", 32'(w), 32'd0);
      chk("R4", "store hit traffic", 32'(wr_n + rd_n), 32'd0);
      access("R4", 1'b0, 31'h008, 4'h0, 32'h0, d, w);
      chk("R4", "merged bytes", d, shad[midx(31'h008)]);
      chk("R4", "memory untouched", mem[midx(31'h008)], seed_word(midx(31'h008)));
   endtask

   task automatic t_store_miss();
      logic [31:0] d; int w;
      access("R5", 1'b1, 31'h044, 4'b1100, 32'h1357_9BDF, d, w);
      chk("R5", "no write on clean miss", 32'(wr_n), 32'd0);
      check_reads("R5", 31'h040);
      chk("R5", "no write-through", mem[midx(31'h044)], seed_word(midx(31'h044)));
      access("R5", 1'b0, 31'h044, 4'h0, 32'h0, d, w);
      chk("R5", "allocated hit", 32'(w), 32'd0);
      chk("R5", "merged after fill", d, shad[midx(31'h044)]);
      access("R5", 1'b0, 31'h05C, 4'h0, 32'h0, d, w);
      chk("R5", "neighbour word", d, shad[midx(31'h05C)]);
   endtask

   task automatic t_dirty_evict();
      logic [31:0] d; int w;
      access("R6", 1'b0, 31'h200, 4'h0, 32'h0, d, w);
      check_writes("R6", 31'h000);
      check_reads("R6", 31'h200);
      chk("R6", "memory holds store", mem[midx(31'h008)], shad[midx(31'h008)]);
      chk("R6", "load after evict", d, shad[midx(31'h200)]);
   endtask

   task automatic t_clean_evict();
      logic [31:0] d; int w;
      access("R7", 1'b0, 31'h00C, 4'h0, 32'h0, d, w);
      chk("R7", "clean victim not written", 32'(wr_n), 32'd0);
      check_reads("R7", 31'h000);
      chk("R7", "reload data", d, shad[midx(31'h00C)]);
   endtask

   task automatic t_high_tag();
      logic [31:0] d; int w;
      access("R9", 1'b1, 31'h300, 4'hF, 32'h1234_5678, d, w);
      access("R9", 1'b0, 31'h4000_0300, 4'h0, 32'h0, d, w);
      chk("R9", "bit 30 alias misses", 32'(w > 0), 32'd1);
      check_writes("R9", 31'h300);
      check_reads("R9", 31'h4000_0300);
      chk("R9", "high line data", d, shad[midx(31'h4000_0300)]);
      access("R9", 1'b0, 31'h300, 4'h0, 32'h0, d, w);
      chk("R7", "high line evicted clean", 32'(wr_n), 32'd0);
      chk("R9", "low line data back", d, 32'h1234_5678);
   endtask

   // ---------------- sequencing ----------------
   initial begin
      for (int i = 0; i < 2048; i++) begin
         mem[i]  = seed_word(i);
         shad[i] = seed_word(i);
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_hit();
      t_store_hit();
      t_store_miss();
      t_dirty_evict();
      t_clean_evict();
      t_high_tag();
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule